// File: doc/BRIEF.md
# Vector Register-Group Overlap Checker

This block sits in a vector decode stage and rules on whether a widening or narrowing vector instruction names a legal set of register groups. It takes the destination and the two source register numbers, the signed LMUL exponent, the log2 width multipliers of the second source and of the destination, a flag that selects narrowing over widening, and a flag that says the first source is a vector register rather than a scalar. From these it reports a fault and a two-bit cause that names the offending operand.

The rules differ by direction. A widening destination may share registers with a source only in its upper registers. A narrowing destination may sit only at the bottom register of a wider source group. A source whose effective LMUL is fractional counts as one register. Narrowing also needs the wide source group to start on a multiple of its own size. Only the checks and the fault report are built here. The output passes through one register stage when `REG_OUT` is 1 (the default), and is combinational when it is 0.

Top module: `vreg_overlap_check`

## Requirements
- R1: Widening, with a vs2 exponent e = vlmul + srcRatioLog2 of 0 or more and group size G = 1 << max(0, vlmul + dstRatioLog2): vs2 is faulty when vs2 < vd + G - (1 << e) and vd < vs2 + (1 << e).
- R2: Widening, with a negative vs2 exponent: vs2 is faulty exactly when vs2 equals vd.
- R3: Widening, with srcRatioLog2 equal to dstRatioLog2: vs2 is never checked.
- R4: Widening with vs1IsVec = 1: vs1 is checked by the R1/R2 rules, using exponent vlmul. With vs1IsVec = 0, vs1 never faults.
- R5: Narrowing, with G = 1 << max(0, vlmul + srcRatioLog2): a source s is faulty when s < vd and vd <= s + G - 1. This applies to vs2 always, and to vs1 only when vs1IsVec = 1.
- R6: Narrowing: vs2 that is not a multiple of G is reported as misaligned. Widening never reports misalignment.
- R7: Cause codes are 0 for none, 1 for vs2 misaligned, 2 for vs2 overlap and 3 for vs1 overlap. The lowest nonzero code that applies wins. fault equals (cause != 0).
- R8: With REG_OUT = 1, outValid, fault and cause show the request one clock after it is presented. When outValid is 0, fault and cause are 0.
- R9: While rst_n is low, outValid and fault are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present |
| isNarrow | input | 1 | 1 = narrowing, 0 = widening |
| vs1IsVec | input | 1 | First source is a vector register |
| vdIdx | input | IDX_W | Destination register number |
| vs1Idx | input | IDX_W | First source register number |
| vs2Idx | input | IDX_W | Second source register number |
| vlmulExp | input | LMUL_W | Signed LMUL exponent |
| srcRatioLog2 | input | RATIO_W | log2 of the vs2 width multiplier |
| dstRatioLog2 | input | RATIO_W | log2 of the destination width multiplier |
| outValid | output | 1 | Result present |
| fault | output | 1 | Illegal register usage |
| cause | output | 2 | Offending operand code |

## Verification
The hardest cases to reach are at the edges of the overlap windows. One is a widening source that lands exactly on the upper register of the destination group. Another is a narrowing destination that sits at the bottom register of the source group. A third is a request that breaks several rules at once, where the priority decides the cause. Random register numbers almost never hit these edges. Directed vectors therefore place the sources one register either side of each bound, and build requests that trip all three checks together. A constrained random sweep then covers every combination of exponent and multiplier.

// File: rtl/vovl_pkg.sv
package vovl_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE      = 2'd0,
    CAUSE_VS2_ALIGN = 2'd1,
    CAUSE_VS2_OVL   = 2'd2,
    CAUSE_VS1_OVL   = 2'd3
  } cause_e;

  // enables handed from control to datapath
  typedef struct packed {
    logic narrowMode;
    logic chkAlign;
    logic chkVs2Ovl;
    logic chkVs1Ovl;
  } chkStrobe_t;

  // raw rule hits returned by the datapath
  typedef struct packed {
    logic vs2Align;
    logic vs2Ovl;
    logic vs1Ovl;
  } ruleHit_t;
endpackage

// File: rtl/vovl_datapath.sv
module vovl_datapath
  import vovl_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int LMUL_W  = 3,
  parameter int RATIO_W = 2
) (
  input  chkStrobe_t               strobe,
  input  logic [IDX_W-1:0]         vdIdx,
  input  logic [IDX_W-1:0]         vs1Idx,
  input  logic [IDX_W-1:0]         vs2Idx,
  input  logic signed [LMUL_W-1:0] vlmulExp,
  input  logic [RATIO_W-1:0]       srcRatioLog2,
  input  logic [RATIO_W-1:0]       dstRatioLog2,
  output ruleHit_t                 hits
);
  // widening window: fractional source is one register, otherwise only
  // the upper part of the destination group may be shared
  function automatic logic wideHit(input int src, input int vd, input int grp, input int e);
    if (e < 0) return src == vd;
    return (src < vd + grp - (1 << e)) && (vd < src + (1 << e));
  endfunction

  // narrowing window: destination may sit only at the bottom of the source group
  function automatic logic narrowHit(input int src, input int vd, input int grp);
    return (src < vd) && (vd <= src + grp - 1);
  endfunction

  always_comb begin
    int vd, s1, s2, lm, sl, dl, grpExp, grp;
    logic rawAlign, rawVs2, rawVs1;
    vd = int'(vdIdx);
    s1 = int'(vs1Idx);
    s2 = int'(vs2Idx);
    lm = int'(vlmulExp);
    sl = int'(srcRatioLog2);
    dl = int'(dstRatioLog2);
    grpExp = strobe.narrowMode ? lm + sl : lm + dl;
    if (grpExp < 0) grpExp = 0;
    grp = 1 << grpExp;
    if (strobe.narrowMode) begin
      rawAlign = (s2 & (grp - 1)) != 0;
      rawVs2   = narrowHit(s2, vd, grp);
      rawVs1   = narrowHit(s1, vd, grp);
    end else begin
      rawAlign = 1'b0;
      rawVs2   = wideHit(s2, vd, grp, lm + sl);
      rawVs1   = wideHit(s1, vd, grp, lm);
    end
    hits.vs2Align = rawAlign & strobe.chkAlign;
    hits.vs2Ovl   = rawVs2 & strobe.chkVs2Ovl;
    hits.vs1Ovl   = rawVs1 & strobe.chkVs1Ovl;
  end
endmodule

// File: rtl/vovl_control.sv
module vovl_control
  import vovl_pkg::*;
#(
  parameter int RATIO_W = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic               isNarrow,
  input  logic               vs1IsVec,
  input  logic [RATIO_W-1:0] srcRatioLog2,
  input  logic [RATIO_W-1:0] dstRatioLog2,
  input  ruleHit_t           hits,
  output chkStrobe_t         strobe,
  output logic               outValid,
  output logic               fault,
  output logic [1:0]         cause
);
  cause_e causeNext;

  always_comb begin
    strobe.narrowMode = isNarrow;
    strobe.chkAlign   = isNarrow;
    strobe.chkVs2Ovl  = isNarrow || (srcRatioLog2 != dstRatioLog2);
    strobe.chkVs1Ovl  = vs1IsVec;
  end

  always_comb begin
    if (!inValid)          causeNext = CAUSE_NONE;
    else if (hits.vs2Align) causeNext = CAUSE_VS2_ALIGN;
    else if (hits.vs2Ovl)   causeNext = CAUSE_VS2_OVL;
    else if (hits.vs1Ovl)   causeNext = CAUSE_VS1_OVL;
    else                    causeNext = CAUSE_NONE;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          outValid <= 1'b0;
          fault    <= 1'b0;
          cause    <= 2'd0;
        end else begin
          outValid <= inValid;
          fault    <= causeNext != CAUSE_NONE;
          cause    <= causeNext;
        end
      end
    end else begin : g_comb
      logic unusedClk;
      assign unusedClk = clk;
      assign outValid  = inValid & rst_n;
      assign fault     = rst_n & (causeNext != CAUSE_NONE);
      assign cause     = rst_n ? causeNext : 2'd0;
    end
  endgenerate
endmodule

// File: rtl/vreg_overlap_check.sv
module vreg_overlap_check
  import vovl_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int LMUL_W  = 3,
  parameter int RATIO_W = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  input  logic                     isNarrow,
  input  logic                     vs1IsVec,
  input  logic [IDX_W-1:0]         vdIdx,
  input  logic [IDX_W-1:0]         vs1Idx,
  input  logic [IDX_W-1:0]         vs2Idx,
  input  logic signed [LMUL_W-1:0] vlmulExp,
  input  logic [RATIO_W-1:0]       srcRatioLog2,
  input  logic [RATIO_W-1:0]       dstRatioLog2,
  output logic                     outValid,
  output logic                     fault,
  output logic [1:0]               cause
);
  chkStrobe_t strobe;
  ruleHit_t   hits;

  vovl_control #(.RATIO_W(RATIO_W), .REG_OUT(REG_OUT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .isNarrow(isNarrow),
    .vs1IsVec(vs1IsVec), .srcRatioLog2(srcRatioLog2), .dstRatioLog2(dstRatioLog2),
    .hits(hits), .strobe(strobe), .outValid(outValid), .fault(fault), .cause(cause)
  );

  vovl_datapath #(.IDX_W(IDX_W), .LMUL_W(LMUL_W), .RATIO_W(RATIO_W)) u_dp (
    .strobe(strobe), .vdIdx(vdIdx), .vs1Idx(vs1Idx), .vs2Idx(vs2Idx),
    .vlmulExp(vlmulExp), .srcRatioLog2(srcRatioLog2), .dstRatioLog2(dstRatioLog2),
    .hits(hits)
  );
endmodule

// File: rtl/vovl_checker.sv
module vovl_checker #(
  parameter int RATIO_W = 2,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic               isNarrow,
  input logic               vs1IsVec,
  input logic [RATIO_W-1:0] srcRatioLog2,
  input logic [RATIO_W-1:0] dstRatioLog2,
  input logic               outValid,
  input logic               fault,
  input logic [1:0]         cause
);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> (!fault && cause == 2'd0));
  // R7
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (fault == (cause != 2'd0)));

  generate
    if (REG_OUT) begin : g_seq
      // R8
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inValid |=> outValid);
      // R8
      valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inValid |=> !outValid);
      // R6
      wide_no_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && !isNarrow) |=> cause != 2'd1);
      // R4
      scalar_vs1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && !vs1IsVec) |=> cause != 2'd3);
      // R3
      same_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inValid && !isNarrow && !vs1IsVec && srcRatioLog2 == dstRatioLog2) |=> !fault);
    end
  endgenerate
endmodule

bind vreg_overlap_check vovl_checker #(.RATIO_W(RATIO_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .isNarrow(isNarrow),
  .vs1IsVec(vs1IsVec), .srcRatioLog2(srcRatioLog2), .dstRatioLog2(dstRatioLog2),
  .outValid(outValid), .fault(fault), .cause(cause)
);

// File: tb/tb_vreg_overlap_check.sv
module tb_vreg_overlap_check;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, isNarrow = 1'b0, vs1IsVec = 1'b0;
  logic [4:0] vdIdx = '0, vs1Idx = '0, vs2Idx = '0;
  logic signed [2:0] vlmulExp = '0;
  logic [1:0] srcRatioLog2 = '0, dstRatioLog2 = '0;
  logic outValid, fault;
  logic [1:0] cause;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vreg_overlap_check dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .isNarrow(isNarrow),
    .vs1IsVec(vs1IsVec), .vdIdx(vdIdx), .vs1Idx(vs1Idx), .vs2Idx(vs2Idx),
    .vlmulExp(vlmulExp), .srcRatioLog2(srcRatioLog2), .dstRatioLog2(dstRatioLog2),
    .outValid(outValid), .fault(fault), .cause(cause)
  );

  function automatic bit wRule(int s, int d, int g, int e);
    if (e < 0) return s == d;
    return (s < d + g - (1 << e)) && (d < s + (1 << e));
  endfunction

  function automatic bit nRule(int s, int d, int g);
    return (s < d) && (d <= s + g - 1);
  endfunction

  // behavioural model of R1..R7
  function automatic int model(bit v, bit nar, bit s1v, int d, int s1, int s2,
                               int lm, int sl, int dl);
    int g;
    if (!v) return 0;
    if (nar) begin
      g = 1 << ((lm + sl) < 0 ? 0 : lm + sl);
      if (s2 % g != 0) return 1;
      if (nRule(s2, d, g)) return 2;
      if (s1v && nRule(s1, d, g)) return 3;
      return 0;
    end
    g = 1 << ((lm + dl) < 0 ? 0 : lm + dl);
    if (sl != dl && wRule(s2, d, g, lm + sl)) return 2;
    if (s1v && wRule(s1, d, g, lm)) return 3;
    return 0;
  endfunction

  task automatic compare(string tag, int expCause, bit expValid);
    total++;
    if (outValid !== expValid || fault !== (expCause != 0) || cause !== 2'(expCause)) begin
      bad++;
      $display("FAIL %s: got valid=%0b fault=%0b cause=%0d, expected valid=%0b fault=%0b cause=%0d",
               tag, outValid, fault, cause, expValid, expCause != 0, expCause);
    end
  endtask

  task automatic apply(string tag, bit v, bit nar, bit s1v, int d, int s1, int s2,
                       int lm, int sl, int dl);
    int exp;
    inValid = v; isNarrow = nar; vs1IsVec = s1v;
    vdIdx = 5'(d); vs1Idx = 5'(s1); vs2Idx = 5'(s2);
    vlmulExp = 3'(lm); srcRatioLog2 = 2'(sl); dstRatioLog2 = 2'(dl);
    exp = model(v, nar, s1v, d, s1, s2, lm, sl, dl);
    @(negedge clk);
    compare(tag, exp, v);
  endtask

  initial begin
    #40000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R9 reset", 0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R9 after release", 0, 1'b0);
    // R1: vlmul=1, widen x2 -> G=4, e=1
    apply("R1 upper overlap ok", 1, 0, 0, 8, 0, 10, 1, 0, 1);
    apply("R1 base overlap",     1, 0, 0, 8, 0, 8,  1, 0, 1);
    apply("R1 below ok",         1, 0, 0, 8, 0, 6,  1, 0, 1);
    apply("R1 straddle",         1, 0, 0, 8, 0, 9,  1, 0, 1);
    // R2: fractional source
    apply("R2 equal",            1, 0, 0, 4, 0, 4, -2, 0, 1);
    apply("R2 differ",           1, 0, 0, 4, 0, 5, -2, 0, 1);
    // R3: equal multipliers
    apply("R3 same ratio",       1, 0, 0, 4, 0, 4,  0, 1, 1);
    // R4: vs1
    apply("R4 vs1 vector hit",   1, 0, 1, 8, 8, 16, 1, 0, 1);
    apply("R4 vs1 scalar",       1, 0, 0, 8, 8, 16, 1, 0, 1);
    apply("R4 vs1 upper ok",     1, 0, 1, 8, 10, 16, 1, 0, 1);
    // R5: narrowing G=4
    apply("R5 vs2 inside",       1, 1, 0, 9, 0, 8,  1, 1, 0);
    apply("R5 vs2 bottom ok",    1, 1, 0, 8, 0, 8,  1, 1, 0);
    apply("R5 vs1 inside",       1, 1, 1, 10, 8, 16, 1, 1, 0);
    apply("R5 vs1 scalar",       1, 1, 0, 10, 8, 16, 1, 1, 0);
    // R6
    apply("R6 misaligned",       1, 1, 0, 0, 0, 6,  1, 1, 0);
    apply("R6 aligned",          1, 1, 0, 0, 0, 4,  1, 1, 0);
    // R7 priority
    apply("R7 align wins",       1, 1, 1, 7, 5, 6,  1, 1, 0);
    apply("R7 vs2 over vs1",     1, 1, 1, 5, 3, 4,  1, 1, 0);
    // R8 idle cycle
    apply("R8 idle",             0, 1, 1, 5, 3, 6,  1, 1, 0);
    // R7 random sweep across exponents and multipliers
    for (int i = 0; i < 400; i++) begin
      apply("R7 random", ($urandom % 8) != 0, $urandom % 2, $urandom % 2,
            $urandom % 32, $urandom % 32, $urandom % 32,
            int'($urandom % 7) - 3, $urandom % 4, $urandom % 4);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule